// File: doc/BRIEF.md
# EEPROM write protection controller

This block decides which bytes of a 256-byte serial EEPROM array may be written. It holds two software protection flags and also looks at the hardware write-protect level. The permanent flag is one-way. The reversible flag can be set and cleared. Either flag guards only the lower half of the array. A high write-protect level guards every byte, whatever the flags hold.

The serial front end decodes a control byte on the protection-register control code. It presents that byte as a one-cycle command together with the current strap levels and a flag meaning that high voltage is present on the lowest strap pin. The block answers in the same cycle with the acknowledge decision.

A write command that is acknowledged becomes pending. It changes a flag only when the front end pulses the commit strobe after a valid stop, and only if the write-protect level is low at that moment. Software learns the state of each flag from whether a query is acknowledged. The data returned by a query carries no meaning.

Top module: `eeprom_wp_ctrl`

## Requirements
- R1: While `wp` is 1, `wr_en` is 0 for every address.
- R2: While `wp` is 0, `wr_en` is 0 for addresses below 80h when either flag is set. It is 1 for addresses 80h and above. With both flags clear, `wr_en` is 1 for every address.
- R3: Command codes on `cmd_op` are 0 = set permanent, 1 = set reversible, 2 = clear reversible, 3 = query permanent and 4 = query reversible. Other values are never acknowledged. A set-permanent command is acknowledged whatever the straps are, as long as the permanent flag is clear. Once the permanent flag is set, no command on any code is acknowledged.
- R4: The ordinary reset `rst_n` leaves both flags unchanged. Only `factory_clr` clears the two flags, and it does so at the next clock edge.
- R5: Set-reversible and query-reversible need the straps to be a2=0, a1=0 and `a0_hv`=1. Clear-reversible needs a2=0, a1=1 and `a0_hv`=1. With any other strap levels these commands are not acknowledged.
- R6: A query is acknowledged exactly when the flag it names is clear, given that the permanent flag is clear and the straps are valid.
- R7: A set-reversible command is not acknowledged while the reversible flag is already set. Clear-reversible is still acknowledged in that case.
- R8: A commit that occurs while `wp` is 1 changes neither flag, even if the command that is pending was acknowledged.
- R9: The flags change only at a `commit` pulse, and only through the last acknowledged write command. A commit also discards the pending command. A commit with nothing pending has no effect. A reset discards the pending command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset; clears the pending command only |
| factory_clr | input | 1 | Synchronous clear of both protection flags |
| cmd_valid | input | 1 | One-cycle strobe for a decoded protection command |
| cmd_op | input | 3 | Command code (see R3) |
| strap_a2 | input | 1 | Level of strap pin a2 |
| strap_a1 | input | 1 | Level of strap pin a1 |
| a0_hv | input | 1 | High voltage is present on strap pin a0 |
| wp | input | 1 | Hardware write-protect level |
| commit | input | 1 | Write-commit strobe after a valid stop |
| wr_addr | input | ADDR_W | Byte address being considered for a write |
| ack | output | 1 | Acknowledge decision for the command presented this cycle |
| wr_en | output | 1 | A write to `wr_addr` is allowed |

## Verification
The bound checker watches several rules on every cycle. It checks that a high write-protect level blocks every address and that the upper half stays open when that level is low. It checks that the permanent flag never falls except through the factory clear, and that an acknowledge never appears once the permanent flag is set. It also checks that the flags hold still unless a commit arrives with the write-protect level low. Other behaviours need scenarios from the bench. These include the strap patterns that select between setting and clearing, the query responses, a pending command that is dropped by a reset, and the permanent flag surviving `rst_n` while falling to `factory_clr`.

// File: rtl/eeprom_wp_ctrl.sv
module eeprom_wp_ctrl #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              factory_clr,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic              strap_a2,
  input  logic              strap_a1,
  input  logic              a0_hv,
  input  logic              wp,
  input  logic              commit,
  input  logic [ADDR_W-1:0] wr_addr,
  output logic              ack,
  output logic              wr_en
);
  localparam logic [2:0] OP_SETP = 3'd0;
  localparam logic [2:0] OP_SETR = 3'd1;
  localparam logic [2:0] OP_CLRR = 3'd2;
  localparam logic [2:0] OP_RDP  = 3'd3;
  localparam logic [2:0] OP_RDR  = 3'd4;

  localparam logic [1:0] PEND_NONE = 2'd0;
  localparam logic [1:0] PEND_SETP = 2'd1;
  localparam logic [1:0] PEND_SETR = 2'd2;
  localparam logic [1:0] PEND_CLRR = 2'd3;

  logic       perm_q, rev_q;
  logic [1:0] pend_q;
  logic       set_strap, clr_strap, low_half;

  assign set_strap = !strap_a2 && !strap_a1 && a0_hv;
  assign clr_strap = !strap_a2 &&  strap_a1 && a0_hv;
  assign low_half  = !wr_addr[ADDR_W-1];

  always_comb begin
    ack = 1'b0;
    if (cmd_valid && !perm_q) begin
      case (cmd_op)
        OP_SETP, OP_RDP: ack = 1'b1;
        OP_SETR, OP_RDR: ack = set_strap && !rev_q;
        OP_CLRR:         ack = clr_strap;
        default:         ack = 1'b0;
      endcase
    end
  end

  assign wr_en = !wp && !(low_half && (perm_q || rev_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= PEND_NONE;
    end else if (ack && cmd_op == OP_SETP) begin
      pend_q <= PEND_SETP;
    end else if (ack && cmd_op == OP_SETR) begin
      pend_q <= PEND_SETR;
    end else if (ack && cmd_op == OP_CLRR) begin
      pend_q <= PEND_CLRR;
    end else if (commit) begin
      pend_q <= PEND_NONE;
    end
  end

  always_ff @(posedge clk) begin
    if (factory_clr) begin
      perm_q <= 1'b0;
      rev_q  <= 1'b0;
    end else if (commit && !wp) begin
      case (pend_q)
        PEND_SETP: perm_q <= 1'b1;
        PEND_SETR: rev_q  <= 1'b1;
        PEND_CLRR: rev_q  <= 1'b0;
        default:   ;
      endcase
    end
  end
endmodule

module eeprom_wp_ctrl_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              factory_clr,
  input logic              cmd_valid,
  input logic [2:0]        cmd_op,
  input logic              wp,
  input logic              commit,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              ack,
  input logic              wr_en,
  input logic              perm_q,
  input logic              rev_q
);
  a_r1_wp_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    wp |-> !wr_en);
  a_r2_upper_open: assert property (@(posedge clk) disable iff (!rst_n)
    (!wp && wr_addr[ADDR_W-1]) |-> wr_en);
  a_r3_perm_nack: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && perm_q) |-> !ack);
  a_r4_perm_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (perm_q && !factory_clr) |=> perm_q);
  a_r7_rev_set_nack: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'd1 && rev_q) |-> !ack);
  a_r8_wp_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && wp && !factory_clr) |=> ($stable(perm_q) && $stable(rev_q)));
  a_r9_only_commit: assert property (@(posedge clk) disable iff (!rst_n)
    (!commit && !factory_clr) |=> ($stable(perm_q) && $stable(rev_q)));
endmodule

bind eeprom_wp_ctrl eeprom_wp_ctrl_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .factory_clr(factory_clr), .cmd_valid(cmd_valid),
  .cmd_op(cmd_op), .wp(wp), .commit(commit), .wr_addr(wr_addr), .ack(ack),
  .wr_en(wr_en), .perm_q(perm_q), .rev_q(rev_q)
);

// File: tb/test_eeprom_wp_ctrl.sv
module test_eeprom_wp_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0, factory_clr = 1'b1, cmd_valid = 1'b0, strap_a2 = 1'b0;
  logic strap_a1 = 1'b0, a0_hv = 1'b0, wp = 1'b0, commit = 1'b0;
  logic [2:0] cmd_op = 3'd0;
  logic [7:0] wr_addr = 8'h00;
  logic ack, wr_en;

  int checks = 0, errors = 0;
  logic m_perm = 1'b0, m_rev = 1'b0;
  logic [1:0] m_pend = 2'd0;
  logic done = 1'b0;

  always #2 clk = ~clk;

  eeprom_wp_ctrl i_eeprom_wp_ctrl (
    .clk(clk), .rst_n(rst_n), .factory_clr(factory_clr), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .strap_a2(strap_a2), .strap_a1(strap_a1), .a0_hv(a0_hv),
    .wp(wp), .commit(commit), .wr_addr(wr_addr), .ack(ack), .wr_en(wr_en)
  );

  function automatic logic exp_ack(logic v, logic [2:0] op, logic a2, logic a1,
                                   logic hv, logic p, logic r);
    if (!v || p) return 1'b0;
    case (op)
      3'd0, 3'd3: return 1'b1;
      3'd1, 3'd4: return !a2 && !a1 && hv && !r;
      3'd2:       return !a2 && a1 && hv;
      default:    return 1'b0;
    endcase
  endfunction

  function automatic logic exp_wen(logic w, logic [7:0] a, logic p, logic r);
    if (w) return 1'b0;
    if (!a[7] && (p || r)) return 1'b0;
    return 1'b1;
  endfunction

  task automatic chk(string tag, logic got, logic exp, string what);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, what, got, exp);
    end
  endtask

  task automatic step(string tag, logic rn, logic fc, logic v, logic [2:0] op,
                      logic a2, logic a1, logic hv, logic w, logic cm,
                      logic [7:0] a);
    logic ea;
    string at;
    @(negedge clk);
    rst_n = rn; factory_clr = fc; cmd_valid = v; cmd_op = op; strap_a2 = a2;
    strap_a1 = a1; a0_hv = hv; wp = w; commit = cm; wr_addr = a;
    #1;
    ea = exp_ack(v, op, a2, a1, hv, m_perm, m_rev);
    if (tag != "") at = tag;
    else if (m_perm || op > 3'd4) at = "R3";
    else if (op == 3'd3 || op == 3'd4) at = "R6";
    else if (op == 3'd1 && m_rev) at = "R7";
    else at = "R5";
    chk(at, ack, ea, "ack");
    chk(tag != "" ? tag : (w ? "R1" : "R2"), wr_en, exp_wen(w, a, m_perm, m_rev), "wr_en");
    if (fc) begin m_perm = 1'b0; m_rev = 1'b0; end
    else if (rn && cm && !w) begin
      if (m_pend == 2'd1) m_perm = 1'b1;
      if (m_pend == 2'd2) m_rev = 1'b1;
      if (m_pend == 2'd3) m_rev = 1'b0;
    end
    if (!rn) m_pend = 2'd0;
    else if (ea && op == 3'd0) m_pend = 2'd1;
    else if (ea && op == 3'd1) m_pend = 2'd2;
    else if (ea && op == 3'd2) m_pend = 2'd3;
    else if (cm) m_pend = 2'd0;
  endtask

  task automatic idle(string tag, logic w, logic [7:0] a);
    step(tag, 1'b1, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, w, 1'b0, a);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    step("R4", 1'b0, 1'b1, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
    step("R4", 1'b1, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h10);
    idle("R1", 1'b1, 8'hF0);
    // R9: acked set reversible, not committed yet
    step("", 1'b1, 1'b0, 1'b1, 3'd1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h05);
    idle("R9", 1'b0, 8'h05);
    step("R9", 1'b1, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h05);
    idle("R9", 1'b0, 8'h05);
    idle("R2", 1'b0, 8'h80);
    step("R7", 1'b1, 1'b0, 1'b1, 3'd1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00);
    step("R6", 1'b1, 1'b0, 1'b1, 3'd4, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00);
    step("R5", 1'b1, 1'b0, 1'b1, 3'd2, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00);
    // R8: clear reversible acked, committed with wp high
    step("R8", 1'b1, 1'b0, 1'b1, 3'd2, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h05);
    step("R8", 1'b1, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h05);
    idle("R8", 1'b0, 8'h05);
    // R9: pending dropped by reset
    step("", 1'b1, 1'b0, 1'b1, 3'd2, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h05);
    step("R9", 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h05);
    step("R9", 1'b1, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h05);
    idle("R9", 1'b0, 8'h05);
    // R3: permanent set with arbitrary straps
    step("R3", 1'b1, 1'b0, 1'b1, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h05);
    step("R3", 1'b1, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h05);
    step("R3", 1'b1, 1'b0, 1'b1, 3'd2, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h05);
    step("R3", 1'b1, 1'b0, 1'b1, 3'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h05);
    // R4: ordinary reset keeps permanent flag, factory clear removes it
    step("R4", 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h20);
    idle("R4", 1'b0, 8'h20);
    step("R4", 1'b1, 1'b1, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h20);
    idle("R4", 1'b0, 8'h20);
    step("R6", 1'b1, 1'b0, 1'b1, 3'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h20);
    for (int i = 0; i < 4000; i++) begin
      logic rn, fc, v, cm;
      rn = ($urandom % 80) != 0;
      fc = ($urandom % 60) == 0;
      v  = ($urandom % 2) == 0;
      cm = ($urandom % 4) == 0;
      step("", rn, fc, v, 3'($urandom % 6), 1'($urandom), 1'($urandom),
           1'($urandom), ($urandom % 3) == 0, cm, 8'($urandom));
    end
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule